// File: doc/BRIEF.md
# Local SRAM Base-Address Decoder

This block owns the placement of a small set of on-chip SRAM banks (two by default, 2 Kbytes each) in the 32-bit address space, and steers every access made on the core's data bus and instruction bus. Each bank has one configuration register. That register holds four things:

- the bank's base address, aligned to 2 Kbytes;
- a bit that ties the bank to either the data bus or the instruction bus;
- a write-protect bit;
- an enable bit.

Software on the core can only write these registers. A debug port can both read and write them.

For each access request, the block decides in the same cycle where the access goes:

- **To an SRAM bank**, with a one-hot bank select and a write strobe.
- **To the cache**, when no bank hits and the address is cacheable.
- **To the external bus**, when no bank hits and the address is not cacheable.
- **Nowhere, with an access error**, when a write lands in a protected bank. The error blocks the write and stops the access from going anywhere else.

Top module: `sram_base_decoder`

## Requirements
- R1: An active-low reset clears the enable bit (bit 0) of every bank register. Reset leaves the base, bus and protect fields at their previous values. With the enable bit at 0, a bank produces no hit.
- R2: A CPU write updates a bank register on the next clock edge. Offset 0xC04 writes bank 0 and 0xC05 writes bank 1. A CPU write to any other offset changes no register.
- R3: The debug port writes the same two offsets and reads them back combinationally on `dbg_rdata_o`. If the debug port and the CPU write the same register in the same cycle, the debug data is stored.
- R4: The stored fields are bits 31:11 (base), bit 8 (write protect), bit 7 (bus select) and bit 0 (enable). All other bits, including 10:9 and 6:1, ignore writes and read back as zero.
- R5: A request hits a bank when all three conditions hold: the enable bit is set, address bits 31:11 equal the base, and the bus matches bit 7. On a hit the route is 1 (SRAM) and `*_bank_sel_o` is one-hot, with bit b meaning bank b.
- R6: Bit 7 = 0 binds a bank to the data bus and bit 7 = 1 to the instruction bus. A matching address on the other bus does not hit.
- R7: A request with no hit gets route 2 (cache) when its cacheable flag is 1, and route 3 (external) otherwise. Without a request, the route is 0 (none), the bank select is zero and the error flag is low.
- R8: On a write hit to a bank with bit 8 clear, `*_sram_we_o` goes high. On a write hit to a bank with bit 8 set, the error flag goes high, the route is 0, the select is zero and the write strobe is low. A read hit to a protected bank is served normally.
- R9: When several enabled banks match, the lowest-numbered bank wins.
- R10: All routing outputs follow the request inputs combinationally within the same cycle.
- R11: A bank covers exactly 2 Kbytes. The last byte, base+0x7FF, hits; base+0x800 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_wr_en_i | input | 1 | CPU register write strobe |
| cpu_wr_addr_i | input | 12 | CPU-space register offset |
| cpu_wr_data_i | input | 32 | CPU write data |
| dbg_en_i | input | 1 | Debug register access strobe |
| dbg_we_i | input | 1 | Debug write (1) or read (0) |
| dbg_addr_i | input | 12 | Debug register offset |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_rdata_o | output | 32 | Debug read data, zero when no register is addressed |
| d_req_i | input | 1 | Data bus access request |
| d_addr_i | input | 32 | Data bus address |
| d_we_i | input | 1 | Data bus write |
| d_cache_i | input | 1 | Data bus address is cacheable |
| d_bank_sel_o | output | 2 | Data bus one-hot bank select |
| d_sram_we_o | output | 1 | Data bus SRAM write strobe |
| d_route_o | output | 2 | Data bus route: 0 none, 1 SRAM, 2 cache, 3 external |
| d_err_o | output | 1 | Data bus access error |
| i_req_i | input | 1 | Instruction bus access request |
| i_addr_i | input | 32 | Instruction bus address |
| i_we_i | input | 1 | Instruction bus write |
| i_cache_i | input | 1 | Instruction bus address is cacheable |
| i_bank_sel_o | output | 2 | Instruction bus one-hot bank select |
| i_sram_we_o | output | 1 | Instruction bus SRAM write strobe |
| i_route_o | output | 2 | Instruction bus route code |
| i_err_o | output | 1 | Instruction bus access error |

## Verification
The hardest situation to reach is two enabled banks matching the same address on the same bus. The stimulus gets there in two steps. First, a same-cycle debug and CPU write to bank 1 stores the debug value, which moves bank 1 onto bank 0's window. Then bank 0 is disabled through the debug port, which shows that bank 1 takes over.

A second hard case is a reset in the middle of the run. After it, the debug port reads back base fields that have kept their values while the enable bits are cleared. A read before reset does not separate this from a design that clears every field, and a design that never clears the enable bit still routes such an address to SRAM; reading back after the reset separates both.

// File: rtl/sram_dec_pkg.sv
package sram_dec_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_SRAM  = 2'd1,
    ROUTE_CACHE = 2'd2,
    ROUTE_EXT   = 2'd3
  } route_e;

  localparam int VALID_BIT = 0;
  localparam int BUS_BIT   = 7;
  localparam int WP_BIT    = 8;
endpackage

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg
  import sram_dec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_LOG2  = 11,
  parameter int REG_ADDR_W = 12,
  parameter logic [REG_ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_we_i,
  input  logic [REG_ADDR_W-1:0] cpu_addr_i,
  input  logic [ADDR_W-1:0]     cpu_wdata_i,
  input  logic                  dbg_we_i,
  input  logic [REG_ADDR_W-1:0] dbg_addr_i,
  input  logic [ADDR_W-1:0]     dbg_wdata_i,
  output logic [ADDR_W-1:0]     cfg_o
);
  localparam int BASE_W = ADDR_W - PAGE_LOG2;
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WMASK  = ~((ONE << PAGE_LOG2) - ONE)
                                         | (ONE << WP_BIT) | (ONE << BUS_BIT) | ONE;

  logic              cpu_hit, dbg_hit, wr;
  logic [ADDR_W-1:0] wdata;
  logic [BASE_W-1:0] base_q;
  logic              bus_q, wp_q, valid_q;

  assign cpu_hit = cpu_we_i && (cpu_addr_i == MY_ADDR);
  assign dbg_hit = dbg_we_i && (dbg_addr_i == MY_ADDR);
  assign wr      = cpu_hit || dbg_hit;
  // debug port wins a same-cycle collision
  assign wdata   = dbg_hit ? dbg_wdata_i : cpu_wdata_i;

  // field storage survives reset
  always_ff @(posedge clk_i) begin
    if (wr) begin
      base_q <= wdata[ADDR_W-1:PAGE_LOG2];
      bus_q  <= wdata[BUS_BIT];
      wp_q   <= wdata[WP_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  valid_q <= 1'b0;
    else if (wr)  valid_q <= wdata[VALID_BIT];
  end

  always_comb begin
    cfg_o                          = '0;
    cfg_o[ADDR_W-1:PAGE_LOG2]      = base_q;
    cfg_o[WP_BIT]                  = wp_q;
    cfg_o[BUS_BIT]                 = bus_q;
    cfg_o[VALID_BIT]               = valid_q;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_valid_clr_R1: assert (!valid_q);
  end

  assert_wr_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> cfg_o == ($past(wdata) & WMASK));

  assert_dbg_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_hit && dbg_hit) |=> cfg_o == ($past(dbg_wdata_i) & WMASK));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && $past(rst_ni)) |=> $stable(cfg_o));
endmodule

// File: rtl/bank_match.sv
module bank_match
  import sram_dec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 11,
  parameter bit BUS_ID    = 1'b0
) (
  input  logic [ADDR_W-1:0] cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = cfg_i[VALID_BIT]
              && (cfg_i[BUS_BIT] == BUS_ID)
              && (addr_i[ADDR_W-1:PAGE_LOG2] == cfg_i[ADDR_W-1:PAGE_LOG2]);
endmodule

// File: rtl/bus_router.sv
module bus_router
  import sram_dec_pkg::*;
#(
  parameter int N_BANKS   = 2,
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 11,
  parameter bit BUS_ID    = 1'b0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_BANKS-1:0][ADDR_W-1:0]   cfg_i,
  input  logic                             req_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             we_i,
  input  logic                             cache_i,
  output logic [N_BANKS-1:0]               bank_sel_o,
  output logic                             sram_we_o,
  output logic [1:0]                       route_o,
  output logic                             err_o
);
  logic [N_BANKS-1:0] hit, first_hit, wp_vec;
  logic               wp_hit;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_match
    bank_match #(
      .ADDR_W   (ADDR_W),
      .PAGE_LOG2(PAGE_LOG2),
      .BUS_ID   (BUS_ID)
    ) u_match (
      .cfg_i (cfg_i[b]),
      .addr_i(addr_i),
      .hit_o (hit[b])
    );
    assign wp_vec[b] = cfg_i[b][WP_BIT];
  end

  // isolate lowest set bit: bank 0 has top priority
  assign first_hit = hit & (~hit + N_BANKS'(1));
  assign wp_hit    = |(first_hit & wp_vec);

  always_comb begin
    bank_sel_o = '0;
    sram_we_o  = 1'b0;
    route_o    = ROUTE_NONE;
    err_o      = 1'b0;
    if (req_i) begin
      if (|hit) begin
        if (we_i && wp_hit) begin
          err_o = 1'b1;
        end else begin
          route_o    = ROUTE_SRAM;
          bank_sel_o = first_hit;
          sram_we_o  = we_i;
        end
      end else if (cache_i) begin
        route_o = ROUTE_CACHE;
      end else begin
        route_o = ROUTE_EXT;
      end
    end
  end

  assert_sel_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_sel_o));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (route_o == ROUTE_NONE) && !err_o && (bank_sel_o == '0));

  assert_err_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !sram_we_o && (route_o == ROUTE_NONE) && we_i && req_i);

  assert_we_path_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> we_i && (route_o == ROUTE_SRAM));

  assert_sel_route_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_sel_o != '0) |-> (route_o == ROUTE_SRAM));
endmodule

// File: rtl/sram_base_decoder.sv
module sram_base_decoder
  import sram_dec_pkg::*;
#(
  parameter int N_BANKS    = 2,
  parameter int ADDR_W     = 32,
  parameter int PAGE_LOG2  = 11,
  parameter int REG_ADDR_W = 12,
  parameter int REG_OFFSET = 'hC04
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_wr_en_i,
  input  logic [REG_ADDR_W-1:0] cpu_wr_addr_i,
  input  logic [ADDR_W-1:0]     cpu_wr_data_i,
  input  logic                  dbg_en_i,
  input  logic                  dbg_we_i,
  input  logic [REG_ADDR_W-1:0] dbg_addr_i,
  input  logic [ADDR_W-1:0]     dbg_wdata_i,
  output logic [ADDR_W-1:0]     dbg_rdata_o,
  input  logic                  d_req_i,
  input  logic [ADDR_W-1:0]     d_addr_i,
  input  logic                  d_we_i,
  input  logic                  d_cache_i,
  output logic [N_BANKS-1:0]    d_bank_sel_o,
  output logic                  d_sram_we_o,
  output logic [1:0]            d_route_o,
  output logic                  d_err_o,
  input  logic                  i_req_i,
  input  logic [ADDR_W-1:0]     i_addr_i,
  input  logic                  i_we_i,
  input  logic                  i_cache_i,
  output logic [N_BANKS-1:0]    i_bank_sel_o,
  output logic                  i_sram_we_o,
  output logic [1:0]            i_route_o,
  output logic                  i_err_o
);
  localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WMASK = ~((ONE << PAGE_LOG2) - ONE)
                                        | (ONE << WP_BIT) | (ONE << BUS_BIT) | ONE;

  logic [N_BANKS-1:0][ADDR_W-1:0] cfg;
  logic                           dbg_wr;

  assign dbg_wr = dbg_en_i && dbg_we_i;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    bank_cfg_reg #(
      .ADDR_W    (ADDR_W),
      .PAGE_LOG2 (PAGE_LOG2),
      .REG_ADDR_W(REG_ADDR_W),
      .MY_ADDR   (REG_ADDR_W'(REG_OFFSET + b))
    ) u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cpu_we_i   (cpu_wr_en_i),
      .cpu_addr_i (cpu_wr_addr_i),
      .cpu_wdata_i(cpu_wr_data_i),
      .dbg_we_i   (dbg_wr),
      .dbg_addr_i (dbg_addr_i),
      .dbg_wdata_i(dbg_wdata_i),
      .cfg_o      (cfg[b])
    );
  end

  always_comb begin
    dbg_rdata_o = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (dbg_en_i && (dbg_addr_i == REG_ADDR_W'(REG_OFFSET + b)))
        dbg_rdata_o = cfg[b];
    end
  end

  bus_router #(
    .N_BANKS(N_BANKS), .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .BUS_ID(1'b0)
  ) u_dbus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .req_i     (d_req_i),
    .addr_i    (d_addr_i),
    .we_i      (d_we_i),
    .cache_i   (d_cache_i),
    .bank_sel_o(d_bank_sel_o),
    .sram_we_o (d_sram_we_o),
    .route_o   (d_route_o),
    .err_o     (d_err_o)
  );

  bus_router #(
    .N_BANKS(N_BANKS), .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .BUS_ID(1'b1)
  ) u_ibus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .req_i     (i_req_i),
    .addr_i    (i_addr_i),
    .we_i      (i_we_i),
    .cache_i   (i_cache_i),
    .bank_sel_o(i_bank_sel_o),
    .sram_we_o (i_sram_we_o),
    .route_o   (i_route_o),
    .err_o     (i_err_o)
  );

  assert_rsvd_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_rdata_o & ~WMASK) == '0);

  assert_rd_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_en_i |-> dbg_rdata_o == '0);
endmodule

// File: tb/sram_base_decoder_test.sv
`timescale 1ns/1ps
module sram_base_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [11:0] cpu_wr_addr = '0;
  logic [31:0] cpu_wr_data = '0;
  logic        dbg_en = 1'b0, dbg_we = 1'b0;
  logic [11:0] dbg_addr = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        d_req = 1'b0, d_we = 1'b0, d_cache = 1'b0;
  logic [31:0] d_addr = '0;
  logic [1:0]  d_sel, d_route;
  logic        d_swe, d_err;
  logic        i_req = 1'b0, i_we = 1'b0, i_cache = 1'b0;
  logic [31:0] i_addr = '0;
  logic [1:0]  i_sel, i_route;
  logic        i_swe, i_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0]  a_route, a_sel;
  logic        a_we, a_err;
  logic [31:0] rd;

  always #2 clk = ~clk;

  sram_base_decoder uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_wr_en_i(cpu_wr_en), .cpu_wr_addr_i(cpu_wr_addr), .cpu_wr_data_i(cpu_wr_data),
    .dbg_en_i(dbg_en), .dbg_we_i(dbg_we), .dbg_addr_i(dbg_addr),
    .dbg_wdata_i(dbg_wdata), .dbg_rdata_o(dbg_rdata),
    .d_req_i(d_req), .d_addr_i(d_addr), .d_we_i(d_we), .d_cache_i(d_cache),
    .d_bank_sel_o(d_sel), .d_sram_we_o(d_swe), .d_route_o(d_route), .d_err_o(d_err),
    .i_req_i(i_req), .i_addr_i(i_addr), .i_we_i(i_we), .i_cache_i(i_cache),
    .i_bank_sel_o(i_sel), .i_sram_we_o(i_swe), .i_route_o(i_route), .i_err_o(i_err)
  );

  // {bus, addr, we, cache, route, sel, sram_we, err}
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 32'h1000_0004, 1'b0, 1'b0, 2'd1, 2'b01, 1'b0, 1'b0},
    {1'b0, 32'h1000_07FC, 1'b1, 1'b0, 2'd1, 2'b01, 1'b1, 1'b0},
    {1'b0, 32'h1000_0800, 1'b0, 1'b1, 2'd2, 2'b00, 1'b0, 1'b0},
    {1'b0, 32'h1000_0800, 1'b0, 1'b0, 2'd3, 2'b00, 1'b0, 1'b0},
    {1'b1, 32'h1000_0000, 1'b0, 1'b0, 2'd3, 2'b00, 1'b0, 1'b0},
    {1'b1, 32'h2000_0810, 1'b0, 1'b0, 2'd1, 2'b10, 1'b0, 1'b0},
    {1'b1, 32'h2000_0810, 1'b1, 1'b1, 2'd0, 2'b00, 1'b0, 1'b1},
    {1'b0, 32'h2000_0810, 1'b0, 1'b1, 2'd2, 2'b00, 1'b0, 1'b0},
    {1'b1, 32'h2000_0FFF, 1'b0, 1'b0, 2'd1, 2'b10, 1'b0, 1'b0},
    {1'b1, 32'h2000_1000, 1'b0, 1'b1, 2'd2, 2'b00, 1'b0, 1'b0}
  };
  string vtag [NV] = '{"R5", "R8", "R11", "R7", "R6", "R5", "R8", "R6", "R11", "R11"};

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = a; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic dbg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    dbg_en = 1'b1; dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_en = 1'b0; dbg_we = 1'b0;
  endtask

  task automatic dbg_read(input logic [11:0] a);
    @(negedge clk);
    dbg_en = 1'b1; dbg_we = 1'b0; dbg_addr = a;
    #1 rd = dbg_rdata;
    dbg_en = 1'b0;
  endtask

  task automatic access(input logic bus, input logic [31:0] a, input logic w, input logic c);
    @(negedge clk);
    if (!bus) begin d_req = 1'b1; d_addr = a; d_we = w; d_cache = c; end
    else      begin i_req = 1'b1; i_addr = a; i_we = w; i_cache = c; end
    #1;
    if (!bus) begin a_route = d_route; a_sel = d_sel; a_we = d_swe; a_err = d_err; end
    else      begin a_route = i_route; a_sel = i_sel; a_we = i_swe; a_err = i_err; end
    d_req = 1'b0; i_req = 1'b0; d_we = 1'b0; i_we = 1'b0;
  endtask

  task automatic chk_route(input string tag, input logic [1:0] r, input logic [1:0] s,
                           input logic w, input logic e);
    chk({tag, " route"}, 32'(a_route), 32'(r));
    chk({tag, " sel"},   32'(a_sel),   32'(s));
    chk({tag, " we"},    32'(a_we),    32'(w));
    chk({tag, " err"},   32'(a_err),   32'(e));
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: enable bits cleared by reset, no hit anywhere
    dbg_read(12'hC04); chk("R1 bank0 enable", 32'(rd[0]), 32'd0);
    dbg_read(12'hC05); chk("R1 bank1 enable", 32'(rd[0]), 32'd0);
    access(1'b0, 32'h0000_0000, 1'b0, 1'b1); chk_route("R1", 2'd2, 2'b00, 1'b0, 1'b0);
    // R7: idle bus
    @(negedge clk); #1;
    chk("R7 idle route", 32'(d_route), 32'd0);
    chk("R7 idle err", 32'(i_err), 32'd0);

    // R2: CPU writes and readback
    cpu_write(12'hC04, 32'h1000_0001);
    cpu_write(12'hC05, 32'h2000_0981);
    dbg_read(12'hC04); chk("R2 bank0", rd, 32'h1000_0001);
    dbg_read(12'hC05); chk("R2 bank1", rd, 32'h2000_0981);
    cpu_write(12'hC06, 32'hFFFF_FFFF);
    dbg_read(12'hC04); chk("R2 stray offset bank0", rd, 32'h1000_0001);
    dbg_read(12'hC05); chk("R2 stray offset bank1", rd, 32'h2000_0981);

    // vector table: R5 R6 R7 R8 R11
    for (int k = 0; k < NV; k++) begin
      access(VEC[k][40], VEC[k][39:8], VEC[k][7], VEC[k][6]);
      chk_route(vtag[k], VEC[k][5:4], VEC[k][3:2], VEC[k][1], VEC[k][0]);
    end

    // R10: outputs follow inputs inside one cycle
    @(negedge clk);
    d_req = 1'b1; d_addr = 32'h1000_0010; d_cache = 1'b0;
    #1 chk("R10 first", 32'(d_route), 32'd1);
    d_addr = 32'h3000_0000;
    #0.5 chk("R10 second", 32'(d_route), 32'd3);
    d_req = 1'b0;

    // R4: reserved bits dropped
    dbg_write(12'hC05, 32'hFFFF_FFFF);
    dbg_read(12'hC05); chk("R4 reserved zero", rd, 32'hFFFF_F981);

    // R3: debug wins same-cycle collision
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_addr = 12'hC05; cpu_wr_data = 32'h0000_0001;
    dbg_en = 1'b1; dbg_we = 1'b1; dbg_addr = 12'hC05; dbg_wdata = 32'h1000_0001;
    @(negedge clk);
    cpu_wr_en = 1'b0; dbg_en = 1'b0; dbg_we = 1'b0;
    dbg_read(12'hC05); chk("R3 collision", rd, 32'h1000_0001);

    // R9: overlap, bank 0 wins; then bank 1 takes over
    access(1'b0, 32'h1000_0010, 1'b0, 1'b0); chk_route("R9 overlap", 2'd1, 2'b01, 1'b0, 1'b0);
    dbg_write(12'hC04, 32'h0000_0000);
    access(1'b0, 32'h1000_0010, 1'b0, 1'b0); chk_route("R9 fallback", 2'd1, 2'b10, 1'b0, 1'b0);

    // R1: reset mid-run keeps fields, clears enable
    cpu_write(12'hC04, 32'h1000_0001);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    dbg_read(12'hC04); chk("R1 bank0 kept", rd, 32'h1000_0000);
    dbg_read(12'hC05); chk("R1 bank1 kept", rd, 32'h1000_0000);
    access(1'b0, 32'h1000_0010, 1'b0, 1'b0); chk_route("R1 post reset", 2'd3, 2'b00, 1'b0, 1'b0);

    summary();
  end
endmodule